// File: doc/BRIEF.md
# Calendar Real-Time Clock

This block is a register-mapped wall clock. It holds the time of day and the calendar date as packed binary fields spread over two 32-bit counter words. The fields are second, minute, hour, day of month, month, year within the century, and century. Each single-cycle pulse on a one-second tick input moves the time forward by one second. The carry runs through minutes, hours and days, follows the month lengths and the leap-year rule, and continues through month, year and century.

Software reaches the block through a plain word-aligned register port. A write strobe with an address and data is taken on the clock edge, and read data follows the address combinationally. The port has no back-pressure: every access finishes in one cycle, so no valid/ready pair exists. A control word holds a run-enable bit and a write-unlock bit. The counter words can only be loaded while unlocked, and time only moves while enabled. Reset leaves the clock stopped, locked and all zero. The alarm and alarm-status addresses are decoded but carry no function.

Top module: `rtc_cal_top`

## Requirements
- R1: After reset every readable location returns zero, so the clock starts disabled and locked with all time fields zero.
- R2: The control word sits at byte offset 0x10 and a write to it is always taken. Bit 0 is run-enable and bit 1 is write-unlock. All its other bits read as zero.
- R3: A write to a counter word (byte offset 0x00 or 0x04) is dropped unless the unlock bit is already set before that write's clock edge.
- R4: Counter word 1 (offset 0x00) packs the day of month in bits 28:24, the hour in 20:16, the minute in 13:8 and the second in 5:0. Its unused bits read zero and are discarded on write.
- R5: Counter word 2 (offset 0x04) packs the century in bits 20:16, the year within the century in 14:8 and the month (1 to 12) in 3:0. Its unused bits read zero and are discarded on write.
- R6: Time advances by one second on each clock where the tick is high and enable was set before that edge. With enable clear, the counter words hold and read back their last value.
- R7: The second rolls from 59 to 0 and carries into the minute. The minute rolls from 59 to 0 and carries into the hour. The hour rolls from 23 to 0 and carries into the day.
- R8: The day rolls to 1 after 30 days in April, June, September and November, and after 31 days in the other months apart from February, then carries into the month.
- R9: February ends after day 29 when the full year (century*100 + year) is divisible by 4 and not by 100, or is divisible by 400. Otherwise it ends after day 28.
- R10: The month rolls from 12 to 1 and carries into the year. The year rolls from 99 to 0 and carries into the century, which wraps from 31 to 0.
- R11: An accepted counter write lands on the next clock edge and replaces any tick advance in that same cycle.
- R12: The alarm (0x08) and alarm-status (0x14) offsets, and every unmapped offset, read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1s | input | 1 | One-second pulse, one clock wide |
| bus_wr_en | input | 1 | Write strobe, taken on the clock edge |
| bus_addr | input | ADDR_W | Byte address; bits 1:0 are ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |

## Verification
The assertions assume reset is asserted before the first tick or write. They also assume the tick is sampled on every clock as a plain level, so a tick held high would advance the time once per clock; the stimulus therefore keeps every tick exactly one cycle wide. The field-step and rollover properties hold for any loaded value. Even so, the stimulus loads only in-range calendar values, except in the one test that checks field masking, and it writes the control word only with the enable and unlock combinations it means to exercise.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int WORD_W = 32;

  localparam logic [2:0] IDX_TIME = 3'd0;
  localparam logic [2:0] IDX_DATE = 3'd1;
  localparam logic [2:0] IDX_CTRL = 3'd4;

  localparam int SEC_W = 6;
  localparam int MIN_W = 6;
  localparam int HR_W  = 5;
  localparam int DAY_W = 5;
  localparam int MON_W = 4;
  localparam int YR_W  = 7;
  localparam int CEN_W = 5;

  typedef struct packed {
    logic [CEN_W-1:0] cen;
    logic [YR_W-1:0]  yr;
    logic [MON_W-1:0] mon;
    logic [DAY_W-1:0] day;
    logic [HR_W-1:0]  hr;
    logic [MIN_W-1:0] mn;
    logic [SEC_W-1:0] sec;
  } cal_t;

  function automatic logic leap_year(input logic [CEN_W-1:0] c, input logic [YR_W-1:0] y);
    logic [11:0] full;
    full = 12'(c) * 12'd100 + 12'(y);
    return ((full[1:0] == 2'b00) && ((full % 12'd100) != 12'd0)) ||
           ((full % 12'd400) == 12'd0);
  endfunction

  function automatic logic [DAY_W-1:0] month_len(input logic [MON_W-1:0] m, input logic leap);
    case (m)
      4'd2:                      return leap ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:   return 5'd30;
      default:                   return 5'd31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_cal_wrap.sv
module rtc_cal_wrap #(
  parameter int W   = 6,
  parameter int LOW = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         inc,
  input  logic [W-1:0] top,
  output logic [W-1:0] q,
  output logic         carry
);
  localparam logic [W-1:0] LOW_V = W'(LOW);

  logic at_top;
  assign at_top = (q >= top);
  assign carry  = inc && at_top;

  always_ff @(posedge clk) begin
    if (!rst_n)   q <= '0;
    else if (ld)  q <= ld_val;
    else if (inc) q <= at_top ? LOW_V : q + W'(1);
  end

  AST_WRAP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && inc && q < top) |=> q == $past(q) + W'(1)); // R7
  AST_WRAP_ROLL: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && inc && q >= top) |=> q == LOW_V); // R10
  AST_WRAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && !inc) |=> $stable(q)); // R6
  AST_WRAP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> q == $past(ld_val)); // R11
endmodule

// File: rtl/rtc_cal_chain.sv
module rtc_cal_chain
  import rtc_cal_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              ld_time,
  input  logic              ld_date,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] time_word,
  output logic [WORD_W-1:0] date_word
);
  cal_t now, nxt;
  logic c_sec, c_min, c_hr, c_day, c_mon, c_yr, c_cen;
  logic [DAY_W-1:0] day_top;

  // field extraction of a write (positions are the register layout)
  assign nxt.sec = wdata[5:0];
  assign nxt.mn  = wdata[13:8];
  assign nxt.hr  = wdata[20:16];
  assign nxt.day = wdata[28:24];
  assign nxt.mon = wdata[3:0];
  assign nxt.yr  = wdata[14:8];
  assign nxt.cen = wdata[20:16];

  logic unused_bits;
  assign unused_bits = ^{wdata[31:29], wdata[23:21], wdata[15], wdata[7:6], c_cen};

  assign day_top = month_len(now.mon, leap_year(now.cen, now.yr));

  rtc_cal_wrap #(.W(SEC_W), .LOW(0)) u_sec (
    .clk(clk), .rst_n(rst_n), .ld(ld_time), .ld_val(nxt.sec), .inc(adv),
    .top(6'd59), .q(now.sec), .carry(c_sec));
  rtc_cal_wrap #(.W(MIN_W), .LOW(0)) u_min (
    .clk(clk), .rst_n(rst_n), .ld(ld_time), .ld_val(nxt.mn), .inc(c_sec),
    .top(6'd59), .q(now.mn), .carry(c_min));
  rtc_cal_wrap #(.W(HR_W), .LOW(0)) u_hr (
    .clk(clk), .rst_n(rst_n), .ld(ld_time), .ld_val(nxt.hr), .inc(c_min),
    .top(5'd23), .q(now.hr), .carry(c_hr));
  rtc_cal_wrap #(.W(DAY_W), .LOW(1)) u_day (
    .clk(clk), .rst_n(rst_n), .ld(ld_time), .ld_val(nxt.day), .inc(c_hr),
    .top(day_top), .q(now.day), .carry(c_day));
  rtc_cal_wrap #(.W(MON_W), .LOW(1)) u_mon (
    .clk(clk), .rst_n(rst_n), .ld(ld_date), .ld_val(nxt.mon), .inc(c_day),
    .top(4'd12), .q(now.mon), .carry(c_mon));
  rtc_cal_wrap #(.W(YR_W), .LOW(0)) u_yr (
    .clk(clk), .rst_n(rst_n), .ld(ld_date), .ld_val(nxt.yr), .inc(c_mon),
    .top(7'd99), .q(now.yr), .carry(c_yr));
  rtc_cal_wrap #(.W(CEN_W), .LOW(0)) u_cen (
    .clk(clk), .rst_n(rst_n), .ld(ld_date), .ld_val(nxt.cen), .inc(c_yr),
    .top(5'd31), .q(now.cen), .carry(c_cen));

  assign time_word = {3'b0, now.day, 3'b0, now.hr, 2'b0, now.mn, 2'b0, now.sec};
  assign date_word = {11'b0, now.cen, 1'b0, now.yr, 4'b0, now.mon};

  AST_CHAIN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !ld_time && !ld_date) |=> ($stable(time_word) && $stable(date_word))); // R6
endmodule

// File: rtl/rtc_cal_regs.sv
module rtc_cal_regs
  import rtc_cal_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        ctrl_wdata,
  input  logic [WORD_W-1:0] time_word,
  input  logic [WORD_W-1:0] date_word,
  output logic              run_en,
  output logic              ld_time,
  output logic              ld_date,
  output logic [WORD_W-1:0] bus_rdata
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic [1:0]       ctrl_q;
  logic             hit_time, hit_date, hit_ctrl;

  assign idx      = bus_addr[ADDR_W-1:2];
  assign hit_time = (idx == IDX_W'(IDX_TIME));
  assign hit_date = (idx == IDX_W'(IDX_DATE));
  assign hit_ctrl = (idx == IDX_W'(IDX_CTRL));

  logic unused_low;
  assign unused_low = ^bus_addr[1:0];

  assign run_en  = ctrl_q[0];
  assign ld_time = bus_wr_en && hit_time && ctrl_q[1];
  assign ld_date = bus_wr_en && hit_date && ctrl_q[1];

  always_ff @(posedge clk) begin
    if (!rst_n)                     ctrl_q <= '0;
    else if (bus_wr_en && hit_ctrl) ctrl_q <= ctrl_wdata;
  end

  always_comb begin
    bus_rdata = '0;
    if (hit_time)      bus_rdata = time_word;
    else if (hit_date) bus_rdata = date_word;
    else if (hit_ctrl) bus_rdata = {{(WORD_W-2){1'b0}}, ctrl_q};
  end

  AST_LOCKED_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && (hit_time || hit_date) && !ctrl_q[1]) |-> !(ld_time || ld_date)); // R3
  AST_CTRL_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && hit_ctrl) |=> ctrl_q == $past(ctrl_wdata)); // R2
endmodule

// File: rtl/rtc_cal_top.sv
module rtc_cal_top
  import rtc_cal_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1s,
  input  logic              bus_wr_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata
);
  logic run_en, ld_time, ld_date, adv;
  logic [WORD_W-1:0] time_word, date_word;

  // a loaded word wins over a same-cycle tick
  assign adv = run_en && tick_1s && !(ld_time || ld_date);

  rtc_cal_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
    .ctrl_wdata(bus_wdata[1:0]), .time_word(time_word), .date_word(date_word),
    .run_en(run_en), .ld_time(ld_time), .ld_date(ld_date), .bus_rdata(bus_rdata));

  rtc_cal_chain u_chain (
    .clk(clk), .rst_n(rst_n), .adv(adv), .ld_time(ld_time), .ld_date(ld_date),
    .wdata(bus_wdata), .time_word(time_word), .date_word(date_word));

  AST_NO_RUN_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !ld_time && !ld_date) |=> $stable(time_word)); // R6
endmodule

// File: tb/rtc_cal_top_tb_top.sv
`timescale 1ns/1ps
module rtc_cal_top_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, tick_1s = 1'b0, bus_wr_en = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  int checks = 0, fails = 0;

  int m_sec, m_min, m_hr, m_day, m_mon, m_yr, m_cen, m_en, m_unl;

  always #10 clk = ~clk;

  rtc_cal_top dut_i (.clk(clk), .rst_n(rst_n), .tick_1s(tick_1s), .bus_wr_en(bus_wr_en),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  function automatic int mdays();
    int full = m_cen * 100 + m_yr;
    bit lp = ((full % 4 == 0) && (full % 100 != 0)) || (full % 400 == 0);
    if (m_mon == 2) return lp ? 29 : 28;
    if (m_mon == 4 || m_mon == 6 || m_mon == 9 || m_mon == 11) return 30;
    return 31;
  endfunction

  function automatic logic [31:0] exp_w1();
    return (m_day << 24) | (m_hr << 16) | (m_min << 8) | m_sec;
  endfunction
  function automatic logic [31:0] exp_w2();
    return (m_cen << 16) | (m_yr << 8) | m_mon;
  endfunction

  task automatic advance();
    if (m_sec >= 59) begin m_sec = 0;
      if (m_min >= 59) begin m_min = 0;
        if (m_hr >= 23) begin m_hr = 0;
          if (m_day >= mdays()) begin m_day = 1;
            if (m_mon >= 12) begin m_mon = 1;
              if (m_yr >= 99) begin m_yr = 0; m_cen = (m_cen + 1) % 32; end
              else m_yr++;
            end else m_mon++;
          end else m_day++;
        end else m_hr++;
      end else m_min++;
    end else m_sec++;
  endtask

  task automatic model(input bit wr, input int addr, input logic [31:0] wd, input bit tk);
    int idx = addr >> 2;
    bit acc = wr && (idx < 2) && (m_unl != 0);
    if (acc && idx == 0) begin
      m_day = wd[28:24]; m_hr = wd[20:16]; m_min = wd[13:8]; m_sec = wd[5:0];
    end else if (acc && idx == 1) begin
      m_cen = wd[20:16]; m_yr = wd[14:8]; m_mon = wd[3:0];
    end else if (m_en != 0 && tk) advance();
    if (wr && idx == 4) begin m_en = wd[0]; m_unl = wd[1]; end
  endtask

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic check_at(input string tag, input int addr, input logic [31:0] exp);
    bus_addr = addr[4:0];
    #1 check(tag, bus_rdata, exp);
  endtask

  task automatic compare_all();
    check_at("R4 word1", 0, exp_w1());
    check_at("R5 word2", 4, exp_w2());
    check_at("R2 ctrl", 16, {30'b0, m_unl[0], m_en[0]});
  endtask

  task automatic step(input bit wr, input int addr, input logic [31:0] wd, input bit tk);
    @(negedge clk);
    bus_wr_en = wr; bus_addr = addr[4:0]; bus_wdata = wd; tick_1s = tk;
    @(posedge clk);
    model(wr, addr, wd, tk);
    #2 bus_wr_en = 1'b0; tick_1s = 1'b0;
    compare_all();
  endtask

  task automatic set_time(input int c, input int y, input int mo, input int d,
                          input int h, input int mi, input int s);
    step(1, 0, (d << 24) | (h << 16) | (mi << 8) | s, 0);
    step(1, 4, (c << 16) | (y << 8) | mo, 0);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    m_sec = 0; m_min = 0; m_hr = 0; m_day = 0; m_mon = 0; m_yr = 0; m_cen = 0; m_en = 0; m_unl = 0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1: reset state on every offset
    for (int a = 0; a < 32; a += 4) check_at("R1 reset", a, 32'h0);

    // R3: locked counter writes dropped
    step(1, 0, 32'h1234_5678, 0);
    step(1, 4, 32'h0014_1801, 0);
    check_at("R3 locked word1", 0, 32'h0);
    check_at("R3 locked word2", 4, 32'h0);

    // R2: control write with junk bits, unlock only
    step(1, 16, 32'hFFFF_FFFE, 0);
    check_at("R2 ctrl masked", 16, 32'h2);

    // R4 / R5: field masking
    step(1, 0, 32'hFFFF_FFFF, 0);
    check_at("R4 mask", 0, 32'h1F1F_3F3F);
    step(1, 4, 32'hFFFF_FFFF, 0);
    check_at("R5 mask", 4, 32'h001F_7F0F);

    step(1, 16, 32'h3, 0);
    // R10 / R7: end of year into new century
    set_time(20, 99, 12, 31, 23, 59, 59);
    step(0, 0, 0, 1);
    check_at("R7 full carry", 0, 32'h0100_0000);
    check_at("R10 year to century", 4, 32'h0015_0001);

    // R9: 2100 not leap
    set_time(21, 0, 2, 28, 23, 59, 59);
    step(0, 0, 0, 1);
    check_at("R9 2100 feb", 4, 32'h0015_0003);
    // R9: 2024 leap
    set_time(20, 24, 2, 28, 23, 59, 59);
    step(0, 0, 0, 1);
    check_at("R9 2024 feb29", 0, 32'h1D00_0000);
    set_time(20, 24, 2, 29, 23, 59, 59);
    step(0, 0, 0, 1);
    check_at("R9 2024 mar1", 4, 32'h0014_1803);
    // R9: 2000 leap
    set_time(20, 0, 2, 28, 23, 59, 59);
    step(0, 0, 0, 1);
    check_at("R9 2000 feb29", 0, 32'h1D00_0000);

    // R8: 30-day month
    set_time(20, 23, 4, 30, 23, 59, 59);
    step(0, 0, 0, 1);
    check_at("R8 apr30", 4, 32'h0014_1705);
    check_at("R8 day1", 0, 32'h0100_0000);

    // R10: century wraps
    set_time(31, 99, 12, 31, 23, 59, 59);
    step(0, 0, 0, 1);
    check_at("R10 century wrap", 4, 32'h0000_0001);

    // R7: minute and hour carry
    set_time(20, 23, 6, 5, 10, 59, 59);
    step(0, 0, 0, 1);
    check_at("R7 hour carry", 0, 32'h050B_0000);

    // R11: write beats tick
    step(1, 0, 32'h050C_2238, 1);
    check_at("R11 write wins", 0, 32'h050C_2238);

    // R6: disabled holds
    step(1, 16, 32'h2, 0);
    for (int i = 0; i < 5; i++) step(0, 0, 0, 1);
    check_at("R6 held", 0, 32'h050C_2238);
    step(1, 16, 32'h0, 0);
    step(1, 0, 32'h0101_0101, 1);
    check_at("R6 R3 held locked", 0, 32'h050C_2238);

    // R12: dead offsets
    step(1, 16, 32'h3, 0);
    step(1, 8, 32'hFFFF_FFFF, 0);
    step(1, 20, 32'hFFFF_FFFF, 0);
    step(1, 12, 32'hFFFF_FFFF, 0);
    step(1, 24, 32'hFFFF_FFFF, 0);
    step(1, 28, 32'hFFFF_FFFF, 0);
    check_at("R12 alarm", 8, 32'h0);
    check_at("R12 status", 20, 32'h0);
    check_at("R12 unmapped", 12, 32'h0);
    check_at("R12 ctrl kept", 16, 32'h3);

    // long runs: ticks on every cycle and sparse ticks across month ends
    set_time(20, 23, 1, 31, 23, 58, 0);
    for (int i = 0; i < 4000; i++) step(0, 0, 0, 1);
    set_time(20, 24, 2, 28, 23, 59, 0);
    for (int i = 0; i < 3000; i++) step(0, 0, 0, (i % 3) != 0);
    finish_run();
  end
endmodule